// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block compares two single-precision binary floating-point operands, given as raw bit patterns, against one of sixteen predicates picked by a 4-bit code. It returns one result bit. The predicates cover ordered, unordered and signaling forms. An operand is unordered when its exponent field is all ones and its fraction is nonzero. Quiet and signaling NaNs get the same treatment.

The signaling half of the codes (bit 3 set) also flags an invalid operation when an operand is unordered. In that case the block sets a cause bit and a sticky bit. When the invalid trap enable is high, it also requests an exception. All outputs are registered one cycle after the input strobe, and a result-valid signal goes with them. The sticky bit holds until reset. The cause bit describes only the latest strobed compare.

Top module: `fcmp_pred_unit`

## Requirements
- R1: The code selects a predicate in this order, 0 to 15: F, UN, EQ, UEQ, OLT, ULT, OLE, ULE, SF, NGLE, SEQ, NGL, LT, NGE, LE, NGT.
- R2: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are nonzero. If either operand is a NaN, odd codes give 1 and even codes give 0.
- R3: For ordered operands, codes 0, 1, 8 and 9 always give 0.
- R4: For ordered operands, codes 2, 3, 10 and 11 give A==B. Codes 4, 5, 12 and 13 give A<B. Codes 6, 7, 14 and 15 give A<=B.
- R5: Positive and negative zero compare equal. Two infinities of the same sign compare equal.
- R6: Ordering uses sign and magnitude, and subnormal operands keep their full value: they are not flushed.
- R7: A strobed compare with a NaN operand and code bit 3 set sets the invalid cause bit and the sticky bit. Any other strobed compare clears the cause bit.
- R8: The exception request is high exactly when the cause bit is set and the trap enable was 1 at the strobe.
- R9: All outputs update one cycle after the strobe, together with a result-valid pulse. The result, cause and request hold their values while no strobe arrives. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 32 | Operand A bit pattern |
| op_b | input | 32 | Operand B bit pattern |
| pred_code | input | 4 | Predicate select |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| cmp_result | output | 1 | Predicate result |
| inv_cause | output | 1 | Invalid cause for the latest compare |
| inv_sticky | output | 1 | Accumulated invalid flag |
| exc_req | output | 1 | Exception request |

## Verification
The bench builds the block with its default 8-bit exponent and 23-bit fraction, which is single precision.

It drives a set of about forty class representatives through all sixteen codes with the trap both on and off:
- signed zeros
- subnormals at both ends of the range
- normals
- largest finite values
- infinities
- quiet and signaling NaNs

This makes every operand pair of every class reach every predicate.

Expected values come from converting each pattern into a signed integer rank inside the bench. The sticky bit is checked across a sequence of compares, and the reset state is checked as well.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  typedef struct packed {
    logic nan;
    logic eq;
    logic lt;
  } rel_t;

  // predicate bits: [3] signaling, [2:1] relation class, [0] unordered result
  typedef enum logic [1:0] {
    REL_NONE = 2'd0,
    REL_EQ   = 2'd1,
    REL_LT   = 2'd2,
    REL_LE   = 2'd3
  } relsel_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              is_nan,
  output logic              is_zero,
  output logic              sign,
  output logic [WORD_W-2:0] mag
);
  assign sign    = word[WORD_W-1];
  assign mag     = word[WORD_W-2:0];
  assign is_nan  = (&word[WORD_W-2:FRAC_W]) && (|word[FRAC_W-1:0]);
  assign is_zero = ~|mag;
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output rel_t              rel
);
  logic a_nan, a_zero, a_sign, b_nan, b_zero, b_sign;
  logic [WORD_W-2:0] a_mag, b_mag;

  fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ca (
    .word(a), .is_nan(a_nan), .is_zero(a_zero), .sign(a_sign), .mag(a_mag));
  fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cb (
    .word(b), .is_nan(b_nan), .is_zero(b_zero), .sign(b_sign), .mag(b_mag));

  function automatic logic [1:0] order_sm(input logic sa, input logic [WORD_W-2:0] ma,
                                          input logic sb, input logic [WORD_W-2:0] mb,
                                          input logic both_zero);
    // returns {eq, lt}
    if (both_zero)       return 2'b10;
    if (sa != sb)        return {1'b0, sa};
    if (ma == mb)        return 2'b10;
    if (sa)              return {1'b0, ma > mb};
    return {1'b0, ma < mb};
  endfunction

  logic [1:0] ord;
  always_comb begin
    ord     = order_sm(a_sign, a_mag, b_sign, b_mag, a_zero && b_zero);
    rel.nan = a_nan | b_nan;
    rel.eq  = ord[1] & ~rel.nan;
    rel.lt  = ord[0] & ~rel.nan;
  end
endmodule

// File: rtl/fcmp_pred_unit.sv
module fcmp_pred_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [3:0]        pred_code,
  input  logic              inv_trap_en,
  output logic              out_valid,
  output logic              cmp_result,
  output logic              inv_cause,
  output logic              inv_sticky,
  output logic              exc_req
);
  rel_t rel;
  fcmp_relate #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rel (
    .a(op_a), .b(op_b), .rel(rel));

  function automatic logic eval_pred(input logic [3:0] code, input rel_t r);
    relsel_t sel;
    sel = relsel_t'(code[2:1]);
    if (r.nan) return code[0];
    unique case (sel)
      REL_NONE: return 1'b0;
      REL_EQ:   return r.eq;
      REL_LT:   return r.lt;
      default:  return r.lt | r.eq;
    endcase
  endfunction

  // named internal events for the checker
  logic pred_now, invalid_hit;
  assign pred_now    = eval_pred(pred_code, rel);
  assign invalid_hit = in_valid & rel.nan & pred_code[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      cmp_result <= 1'b0;
      inv_cause  <= 1'b0;
      inv_sticky <= 1'b0;
      exc_req    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cmp_result <= pred_now;
        inv_cause  <= invalid_hit;
        exc_req    <= invalid_hit & inv_trap_en;
        if (invalid_hit) inv_sticky <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcmp_pred_checker.sv
module fcmp_pred_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic inv_trap_en,
  input logic out_valid,
  input logic cmp_result,
  input logic inv_cause,
  input logic inv_sticky,
  input logic exc_req,
  input logic invalid_hit
);
  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(cmp_result) && $stable(inv_cause) && $stable(exc_req)));
  assert_sticky_never_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_sticky |=> inv_sticky);
  assert_cause_implies_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_cause |-> inv_sticky);
  assert_req_needs_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> inv_cause);
  assert_req_follows_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (invalid_hit && inv_trap_en) |=> exc_req);
endmodule

bind fcmp_pred_unit fcmp_pred_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv_trap_en(inv_trap_en),
  .out_valid(out_valid), .cmp_result(cmp_result), .inv_cause(inv_cause),
  .inv_sticky(inv_sticky), .exc_req(exc_req), .invalid_hit(invalid_hit));

// File: tb/sim_fcmp_pred_unit.sv
`timescale 1ns/1ps
module sim_fcmp_pred_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, inv_trap_en = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0] pred_code = '0;
  logic out_valid, cmp_result, inv_cause, inv_sticky, exc_req;
  int checks = 0, errors = 0;
  logic [31:0] pats [40];

  always #4 clk = ~clk;

  fcmp_pred_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .pred_code(pred_code), .inv_trap_en(inv_trap_en), .out_valid(out_valid),
    .cmp_result(cmp_result), .inv_cause(inv_cause), .inv_sticky(inv_sticky), .exc_req(exc_req));

  function automatic bit is_nan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction
  // signed rank: magnitude as integer, negated for negative sign (R5, R6)
  function automatic longint rank(input logic [31:0] w);
    longint m = longint'(w[30:0]);
    return w[31] ? -m : m;
  endfunction
  function automatic bit expect_res(input logic [31:0] a, input logic [31:0] b, input int c);
    longint ra, rb;
    if (is_nan(a) || is_nan(b)) return bit'(c % 2);          // R2
    ra = rank(a); rb = rank(b);
    case (c % 8)                                             // R1 table
      0, 1: return 1'b0;                                     // R3
      2, 3: return ra == rb;                                 // R4 equal
      4, 5: return ra < rb;                                  // R4 less
      default: return ra <= rb;                              // R4 less-or-equal
    endcase
  endfunction

  task automatic chk(input bit act, input bit exp_v, input string req);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b a=%h b=%h code=%0d", req, act, exp_v, op_a, op_b, pred_code);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input int c, input bit en);
    bit hit;
    @(negedge clk);
    op_a = a; op_b = b; pred_code = 4'(c); inv_trap_en = en; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    hit = (is_nan(a) || is_nan(b)) && c >= 8;
    chk(out_valid, 1'b1, "R9");
    chk(cmp_result, expect_res(a, b, c), "R1/R4");
    chk(inv_cause, hit, "R7");
    chk(exc_req, hit && en, "R8");
    if (hit) chk(inv_sticky, 1'b1, "R7");
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k = 0;
    logic [31:0] base [10] = '{32'h0000_0000, 32'h0000_0001, 32'h007F_FFFF, 32'h0080_0000,
      32'h3F80_0000, 32'h3F80_0001, 32'h7F7F_FFFF, 32'h7F80_0000, 32'h7FC0_0000, 32'h7F80_0001};
    for (int i = 0; i < 10; i++) begin
      pats[k++] = base[i];
      pats[k++] = base[i] | 32'h8000_0000;
    end
    for (int i = 0; i < 20; i++) pats[k++] = {pats[i][31], pats[i][30:0] ^ 31'h0000_0003} ;

    repeat (3) @(negedge clk);
    chk(out_valid, 1'b0, "R9 reset"); chk(cmp_result, 1'b0, "R9 reset");
    chk(inv_sticky, 1'b0, "R9 reset"); chk(exc_req, 1'b0, "R9 reset");
    rst_n = 1'b1;

    // no NaN yet: sticky must stay low through ordered signaling compares
    run(32'h0000_0000, 32'h8000_0000, 10, 1'b1); // R5 +0 == -0
    chk(inv_sticky, 1'b0, "R7 sticky low");
    run(32'h7F80_0000, 32'h7F80_0000, 14, 1'b1); // R5 inf==inf
    run(32'h0000_0001, 32'h0000_0000, 12, 1'b0); // R6 subnormal > 0

    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 40; i++)
        for (int j = 0; j < 40; j += 3)
          run(pats[i], pats[j], c, bit'((i + j + c) & 1));

    // cause clears on a clean compare, sticky stays (R7), hold while idle (R9)
    run(32'h3F80_0000, 32'h4000_0000, 12, 1'b1);
    chk(inv_cause, 1'b0, "R7 cause cleared");
    chk(inv_sticky, 1'b1, "R7 sticky held");
    repeat (3) @(negedge clk);
    chk(out_valid, 1'b0, "R9 idle"); chk(cmp_result, 1'b1, "R9 hold");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule